// File: doc/BRIEF.md
# System Clock Gate and Power-Down Controller

This block decides whether a small display-controller core has a running system clock and a powered bias generator. A decoded command arrives as a one-cycle strobe with an opcode. Four opcodes act: system enable, system disable, bias on and bias off. The block keeps two state bits, the system state and the bias state, and both reset to off.

One of three clock sources is selected. These are an on-chip RC oscillator at 256 kHz, a 32.768 kHz crystal, and an external 256 kHz clock. Each source supplies a tick indication. The block passes the tick of the selected source on as the system clock enable, but only while the system is enabled.

Full power-down stops the oscillator. It is allowed only when the clock source can actually be halted. That rules out the external clock. It also rules out a crystal input that is being fed by an external signal. With such a source, a system disable still blanks the display and gates the clock enable, but the oscillator keeps running.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: `clk_en` equals the tick of the selected source while the system is enabled. The `src_sel` codes are 0 for RC (`src_tick[0]`), 1 for crystal (`src_tick[1]`), 2 for external (`src_tick[2]`) and 3, which behaves as external.
- R2: After reset the system and the bias are both off. So `disp_blank`=1, `bias_en`=0 and `clk_en`=0.
- R3: Opcode 0 (system disable) turns the system and the bias off from the cycle after the strobe, whatever the source is.
- R4: While source code 2 or 3 is selected, `pwr_down` stays 0 and `osc_run` stays 1.
- R5: While the crystal is selected and `xtal_ext_drv`=1, `pwr_down` stays 0.
- R6: Opcode 2 (bias off) clears only the bias, and the system state is kept. Opcode 3 (bias on) sets the bias only while the system is enabled.
- R7: Opcode 1 (system enable) restarts the clock enable from the next cycle. It does not change the bias state.
- R8: `pwr_down` is 1 exactly when the display is blank, the bias is off and the source can be stopped. `osc_run` is its inverse.
- R9: A strobe with an opcode of 4 or above changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| src_sel | input | 2 | Clock source select |
| xtal_ext_drv | input | 1 | Crystal pin is driven by an external signal |
| src_tick | input | 3 | Per-source clock tick indications |
| clk_en | output | 1 | Gated system clock enable |
| bias_en | output | 1 | Bias generator enable |
| disp_blank | output | 1 | Display blank flag |
| pwr_down | output | 1 | Power-down indication |
| osc_run | output | 1 | Oscillator run request |

## Verification
The assertions assume that a command strobe is sampled on one edge only. They also assume that `src_sel` and `xtal_ext_drv` are stable across that edge, because the checks compare state just before the edge with state just after it. The stimulus drives every input on the falling edge and holds it for a whole cycle. It chooses strobes, opcodes (including the unused codes from 4 to 7), source codes and ticks at random, and adds directed sequences for the external, externally driven crystal and power-down paths.

// File: rtl/clk_pwr_pkg.sv
package clk_pwr_pkg;
  localparam int OP_W   = 4;
  localparam int SEL_W  = 2;
  localparam int NUM_SRC = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SYS_OFF  = 4'd0,
    OP_SYS_ON   = 4'd1,
    OP_BIAS_OFF = 4'd2,
    OP_BIAS_ON  = 4'd3
  } op_e;

  typedef enum logic [SEL_W-1:0] {
    SRC_RC   = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_EXT  = 2'd2
  } src_e;

  typedef struct packed {
    logic sys_on;
    logic bias_on;
  } pwr_state_t;
endpackage

// File: rtl/clk_pwr_state.sv
module clk_pwr_state
  import clk_pwr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  output pwr_state_t      state_q
);
  pwr_state_t state_d;
  logic       st_en;

  // R3 R6 R7 R9: next-state decode; unknown opcodes fall to default
  always_comb begin
    state_d = state_q;
    st_en   = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_op)
        OP_SYS_OFF:  begin state_d.sys_on = 1'b0; state_d.bias_on = 1'b0; st_en = 1'b1; end
        OP_SYS_ON:   begin state_d.sys_on = 1'b1; st_en = 1'b1; end
        OP_BIAS_OFF: begin state_d.bias_on = 1'b0; st_en = 1'b1; end
        OP_BIAS_ON:  begin state_d.bias_on = state_q.sys_on | state_q.bias_on; st_en = 1'b1; end
        default:     st_en = 1'b0;
      endcase
    end
  end

  // R2: both off after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (st_en) begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/clk_src_mux.sv
module clk_src_mux
  import clk_pwr_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic [SEL_W-1:0] src_sel,
  input  logic             xtal_ext_drv,
  input  logic [N_SRC-1:0] src_tick,
  output logic             tick_sel,
  output logic             stoppable
);
  localparam int LAST = N_SRC - 1;
  logic [N_SRC-1:0] hit;

  // R1: one-hot pick; codes beyond the last source map to the last one
  for (genvar g = 0; g < N_SRC; g++) begin : g_pick
    if (g == LAST) begin : g_last
      assign hit[g] = (int'(src_sel) >= g);
    end else begin : g_mid
      assign hit[g] = (int'(src_sel) == g);
    end
  end

  assign tick_sel = |(hit & src_tick);

  // R4 R5: only RC, or a crystal that is really a crystal, may be halted
  always_comb begin
    stoppable = 1'b0;
    if (src_sel == SRC_RC)        stoppable = 1'b1;
    else if (src_sel == SRC_XTAL) stoppable = ~xtal_ext_drv;
  end
endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
  import clk_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [OP_W-1:0]    cmd_op,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               xtal_ext_drv,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               clk_en,
  output logic               bias_en,
  output logic               disp_blank,
  output logic               pwr_down,
  output logic               osc_run
);
  pwr_state_t st;
  logic       tick_sel;
  logic       stoppable;

  clk_pwr_state i_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .state_q   (st)
  );

  clk_src_mux #(.N_SRC(NUM_SRC)) i_mux (
    .src_sel      (src_sel),
    .xtal_ext_drv (xtal_ext_drv),
    .src_tick     (src_tick),
    .tick_sel     (tick_sel),
    .stoppable    (stoppable)
  );

  // R1 R8: outputs derived from state and source
  assign clk_en     = st.sys_on & tick_sel;
  assign bias_en    = st.bias_on;
  assign disp_blank = ~st.sys_on;
  assign pwr_down   = ~st.sys_on & ~st.bias_on & stoppable;
  assign osc_run    = ~pwr_down;
endmodule

// File: rtl/clk_pwr_chk.sv
module clk_pwr_chk
  import clk_pwr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [OP_W-1:0]    cmd_op,
  input logic [SEL_W-1:0]   src_sel,
  input logic               xtal_ext_drv,
  input logic               clk_en,
  input logic               bias_en,
  input logic               disp_blank,
  input logic               pwr_down,
  input logic               osc_run
);
  AST_SYS_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'd0) |=> (disp_blank && !bias_en && !clk_en)); // R3
  AST_EXT_NO_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel >= 2'd2) |-> (!pwr_down && osc_run)); // R4
  AST_XDRV_NO_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd1 && xtal_ext_drv) |-> !pwr_down); // R5
  AST_SYS_ON_BIAS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'd1) |=> (!disp_blank && bias_en == $past(bias_en))); // R7
  AST_BIAS_OFF_KEEPS_SYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'd2) |=> (!bias_en && disp_blank == $past(disp_blank))); // R6
  AST_PD_MEANS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (disp_blank && !bias_en && !clk_en)); // R8
  AST_BLANK_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    disp_blank |-> !clk_en); // R1
  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op >= 4'd4) |=> ($stable(disp_blank) && $stable(bias_en))); // R9
endmodule

bind clk_pwr_ctrl clk_pwr_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .src_sel      (src_sel),
  .xtal_ext_drv (xtal_ext_drv),
  .clk_en       (clk_en),
  .bias_en      (bias_en),
  .disp_blank   (disp_blank),
  .pwr_down     (pwr_down),
  .osc_run      (osc_run)
);

// File: tb/test_clk_pwr_ctrl.sv
module test_clk_pwr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [3:0] cmd_op;
  logic [1:0] src_sel;
  logic       xtal_ext_drv;
  logic [2:0] src_tick;
  logic       clk_en, bias_en, disp_blank, pwr_down, osc_run;

  int n_run = 0;
  int n_fail = 0;
  bit m_sys = 1'b0;
  bit m_bias = 1'b0;

  always #5 clk = ~clk;

  clk_pwr_ctrl i_clk_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .src_sel(src_sel), .xtal_ext_drv(xtal_ext_drv), .src_tick(src_tick),
    .clk_en(clk_en), .bias_en(bias_en), .disp_blank(disp_blank),
    .pwr_down(pwr_down), .osc_run(osc_run)
  );

  function automatic bit can_stop(logic [1:0] sel, logic xd);
    return (sel == 2'd0) || (sel == 2'd1 && !xd);
  endfunction

  function automatic bit pick_tick(logic [1:0] sel, logic [2:0] t);
    return (sel >= 2'd2) ? t[2] : t[sel];
  endfunction

  task automatic chk(string req, string nm, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    bit pd;
    pd = !m_sys && !m_bias && can_stop(src_sel, xtal_ext_drv);
    chk({tag, " R1"}, "clk_en", clk_en, m_sys && pick_tick(src_sel, src_tick));
    chk({tag, " R6"}, "bias_en", bias_en, m_bias);
    chk({tag, " R3"}, "disp_blank", disp_blank, !m_sys);
    chk({tag, " R8"}, "pwr_down", pwr_down, pd);
    chk({tag, " R4"}, "osc_run", osc_run, !pd);
  endtask

  task automatic step(logic v, logic [3:0] op, logic [1:0] sel, logic [2:0] t, logic xd, string tag);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; src_sel = sel; src_tick = t; xtal_ext_drv = xd;
    #1 check_all(tag);
    @(posedge clk);
    if (v) begin
      case (op)
        4'd0: begin m_sys = 1'b0; m_bias = 1'b0; end
        4'd1: m_sys = 1'b1;
        4'd2: m_bias = 1'b0;
        4'd3: if (m_sys) m_bias = 1'b1;
        default: ;
      endcase
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; src_sel = 0; src_tick = 3'b111; xtal_ext_drv = 0;
    repeat (2) @(negedge clk);
    #1;
    chk("R2", "disp_blank", disp_blank, 1);
    chk("R2", "bias_en", bias_en, 0);
    chk("R2", "clk_en", clk_en, 0);
    chk("R2 R8", "pwr_down", pwr_down, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: enable, then bias stays off until bias-on
    step(1, 4'd1, 2'd0, 3'b001, 0, "R7");
    step(0, 4'd0, 2'd0, 3'b001, 0, "R7");
    chk("R7", "bias_en", bias_en, 0);
    step(1, 4'd3, 2'd0, 3'b001, 0, "R6");
    // R6: bias off keeps system running
    step(1, 4'd2, 2'd1, 3'b010, 0, "R6");
    step(0, 4'd0, 2'd1, 3'b010, 0, "R6");
    chk("R6", "clk_en", clk_en, 1);
    // R9: unknown opcodes ignored
    step(1, 4'd3, 2'd1, 3'b010, 0, "R9");
    for (int k = 4; k < 16; k++) step(1, 4'(k), 2'd1, 3'b010, 0, "R9");
    step(0, 4'd0, 2'd1, 3'b010, 0, "R9");
    chk("R9", "bias_en", bias_en, 1);
    // R4: external source, disable does not power down
    step(1, 4'd0, 2'd2, 3'b100, 0, "R4");
    step(0, 4'd0, 2'd2, 3'b100, 0, "R4");
    chk("R4", "osc_run", osc_run, 1);
    step(0, 4'd0, 2'd3, 3'b100, 0, "R4");
    // R5: externally driven crystal
    step(0, 4'd0, 2'd1, 3'b010, 1, "R5");
    chk("R5", "pwr_down", pwr_down, 0);
    // R8: real crystal now powers down
    step(0, 4'd0, 2'd1, 3'b010, 0, "R8");
    chk("R8", "pwr_down", pwr_down, 1);
    // R3: disable with bias on from RC
    step(1, 4'd1, 2'd0, 3'b001, 0, "R3");
    step(1, 4'd3, 2'd0, 3'b001, 0, "R3");
    step(1, 4'd0, 2'd0, 3'b001, 0, "R3");
    step(0, 4'd0, 2'd0, 3'b001, 0, "R3");
    chk("R3", "bias_en", bias_en, 0);
    // R6: bias-on while disabled has no effect
    step(1, 4'd3, 2'd0, 3'b001, 0, "R6");
    step(0, 4'd0, 2'd0, 3'b001, 0, "R6");
    chk("R6", "bias_en", bias_en, 0);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) == 0, 4'($urandom_range(0, 7)), 2'($urandom),
           3'($urandom), 1'($urandom), "rand");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule